// File: doc/BRIEF.md
# Flow-Control PAUSE Frame Generator

This block turns receive-side congestion into link-level flow control. It compares a receive FIFO occupancy value with a programmable threshold. When the occupancy rises past it, the block builds a MAC control PAUSE frame and streams it one byte at a time toward the transmit path of the MAC. The frame asks the link partner to stop sending for a programmable number of 512-bit-time quanta. This frame is the XOFF frame.

The block keeps its own copy of how much of the requested pause is still outstanding. A prescaler divides a bit-time tick by 512 and steps that count down. While the congestion lasts, a fresh XOFF frame goes out once the remaining time has fallen to a programmable lead value. If the occupancy falls back while pause time is still outstanding, one frame with a zero pause length (XON) releases the partner early. Preamble, start delimiter and frame check sequence are added further down the transmit path.

Top module: `pause_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_valid` and `tx_last` are low.
- R2: Congestion means `fifo_level` strictly greater than `level_thresh`; equality is not congestion. When congestion is present and no pause is outstanding (remaining time zero), an XOFF frame carrying `pause_len` begins on the following cycle.
- R3: Every frame is 60 bytes in this order: 01 80 C2 00 00 01, then `src_mac` most significant byte first (bits 47:40 first), then 88 08, then 00 01, then the pause length high byte then low byte, then 42 bytes of 00. `tx_last` is high only with byte 60.
- R4: A byte is consumed only on a cycle with `tx_valid` and `tx_ready` both high; while `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold their values.
- R5: When an XOFF frame's last byte is accepted, the remaining time loads `pause_len`. It then drops by one per 512 `bit_tick` pulses. While congestion persists, a refresh XOFF begins on the cycle after the remaining time becomes less than or equal to `refresh_lead`.
- R6: When congestion is absent and the remaining time is nonzero, one XON frame with pause length 0000 is sent, and its completion clears the remaining time.
- R7: With no congestion and remaining time zero, no frame is started.
- R8: A congestion change seen while a frame is being sent is held: an XOFF frame during which congestion cleared is followed by an XON frame, and an XON frame during which congestion appeared is followed by an XOFF frame.
- R9: Once `tx_valid` rises it stays high until the last byte is accepted; frames never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LEVEL_W | Receive FIFO occupancy |
| level_thresh | input | LEVEL_W | Congestion threshold |
| pause_len | input | TIME_W | Pause length sent in XOFF frames, in 512-bit-time quanta |
| refresh_lead | input | TIME_W | Remaining time at which a refresh XOFF is sent |
| src_mac | input | 48 | Station source address |
| bit_tick | input | 1 | One pulse per bit time |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Transmit path accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The in-line checks take for granted that the transmit path sees valid and ready only through the handshake. They also assume the configuration is held steady while a frame is pending. The bench changes `pause_len`, `refresh_lead`, `level_thresh` and `src_mac` only between frames, and it throttles `tx_ready` at random on every byte. It keeps `refresh_lead` below `pause_len` so that a refresh is never due at the moment of reload. Randomised thresholds and levels include the equality case, which must read as no congestion.

// File: rtl/pause_pkg.sv
package pause_pkg;

   localparam int HDR_BYTES = 18;

   typedef enum logic {
      KIND_XOFF = 1'b0,
      KIND_XON  = 1'b1
   } pause_kind_e;

   function automatic logic [7:0] hdr_byte(input int unsigned idx,
                                           input logic [47:0]  sa,
                                           input logic [15:0]  len);
      logic [7:0] b;
      b = 8'h00;
      if (idx == 0 || idx == 5)        b = 8'h01;
      else if (idx == 1)               b = 8'h80;
      else if (idx == 2)               b = 8'hC2;
      else if (idx >= 6 && idx <= 11)  b = sa[8*(11-idx) +: 8];
      else if (idx == 12)              b = 8'h88;
      else if (idx == 13)              b = 8'h08;
      else if (idx == 15)              b = 8'h01;
      else if (idx == 16)              b = len[15:8];
      else if (idx == 17)              b = len[7:0];
      return b;
   endfunction

endpackage

// File: rtl/pause_timer.sv
module pause_timer #(
   parameter int TIME_W     = 16,
   parameter int PRESCALE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              reload,
   input  logic              clear,
   input  logic [TIME_W-1:0] load_val,
   output logic [TIME_W-1:0] remaining
);
   localparam logic [PRESCALE_W-1:0] PRE_MAX = {PRESCALE_W{1'b1}};

   logic [PRESCALE_W-1:0] pre_q;
   logic [TIME_W-1:0]     rem_q;
   logic                  active;
   logic                  step;

   initial begin
      if (TIME_W < 2)     $error("pause_timer: TIME_W too small");
      if (PRESCALE_W < 1) $error("pause_timer: PRESCALE_W too small");
   end

   assign active = (rem_q != '0);
   assign step   = active && bit_tick && (pre_q == PRE_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         rem_q <= '0;
      end else if (reload) begin
         pre_q <= '0;
         rem_q <= load_val;
      end else if (clear) begin
         pre_q <= '0;
         rem_q <= '0;
      end else if (active && bit_tick) begin
         pre_q <= pre_q + 1'b1;
         if (step) rem_q <= rem_q - 1'b1;
      end
   end

   assign remaining = rem_q;

   // R5
   rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reload) && !$past(clear) && (remaining != $past(remaining)))
      |-> (remaining == $past(remaining) - 1'b1));

endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
   import pause_pkg::*;
#(
   parameter int LEVEL_W     = 10,
   parameter int TIME_W      = 16,
   parameter bit AT_OR_ABOVE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic [LEVEL_W-1:0] level_thresh,
   input  logic [TIME_W-1:0]  remaining,
   input  logic [TIME_W-1:0]  refresh_lead,
   input  logic               ser_busy,
   output logic               start,
   output pause_kind_e        start_kind
);
   logic        cong;
   logic        clr_seen_q;
   logic        cong_seen_q;
   pause_kind_e cur_kind_q;
   logic        xoff_go;
   logic        xon_go;

   initial begin
      if (LEVEL_W < 1) $error("pause_ctrl: LEVEL_W too small");
   end

   generate
      if (AT_OR_ABOVE) begin : g_cmp_ge
         assign cong = (fifo_level >= level_thresh);
      end else begin : g_cmp_gt
         assign cong = (fifo_level > level_thresh);
      end
   endgenerate

   assign xoff_go = (cong && (remaining <= refresh_lead)) || cong_seen_q;
   assign xon_go  = (!cong || clr_seen_q) && (remaining != '0);

   always_comb begin
      start      = 1'b0;
      start_kind = KIND_XOFF;
      if (!ser_busy) begin
         if (xoff_go) begin
            start      = 1'b1;
            start_kind = KIND_XOFF;
         end else if (xon_go) begin
            start      = 1'b1;
            start_kind = KIND_XON;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clr_seen_q  <= 1'b0;
         cong_seen_q <= 1'b0;
         cur_kind_q  <= KIND_XOFF;
      end else if (start) begin
         clr_seen_q  <= 1'b0;
         cong_seen_q <= 1'b0;
         cur_kind_q  <= start_kind;
      end else if (ser_busy) begin
         if (cur_kind_q == KIND_XOFF && !cong) clr_seen_q  <= 1'b1;
         if (cur_kind_q == KIND_XON  &&  cong) cong_seen_q <= 1'b1;
      end
   end

   // R9
   start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ser_busy);

   // R7
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cong && !cong_seen_q && remaining == '0) |-> !start);

endmodule

// File: rtl/pause_ser.sv
module pause_ser
   import pause_pkg::*;
#(
   parameter int TIME_W    = 16,
   parameter int PAD_BYTES = 42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  pause_kind_e       start_kind,
   input  logic [TIME_W-1:0] len_in,
   input  logic [47:0]       sa_in,
   output logic              busy,
   output logic              done_xoff,
   output logic              done_xon,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last
);
   localparam int FRAME_LEN = HDR_BYTES + PAD_BYTES;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   logic [IDX_W-1:0] idx_q;
   logic [15:0]      len_q;
   logic [47:0]      sa_q;
   pause_kind_e      kind_q;
   logic             busy_q;
   logic             fire;
   logic             at_end;

   initial begin
      if (TIME_W != 16)   $error("pause_ser: the frame carries a 16-bit length");
      if (PAD_BYTES < 1)  $error("pause_ser: PAD_BYTES must be positive");
   end

   assign fire   = busy_q && tx_ready;
   assign at_end = (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         len_q  <= '0;
         sa_q   <= '0;
         kind_q <= KIND_XOFF;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            kind_q <= start_kind;
            sa_q   <= sa_in;
            len_q  <= (start_kind == KIND_XON) ? 16'h0000 : 16'(len_in);
         end
      end else if (fire) begin
         if (at_end) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign tx_valid  = busy_q;
   assign tx_data   = busy_q ? hdr_byte(32'(idx_q), sa_q, len_q) : 8'h00;
   assign tx_last   = busy_q && at_end;
   assign done_xoff = fire && at_end && (kind_q == KIND_XOFF);
   assign done_xon  = fire && at_end && (kind_q == KIND_XON);

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R3
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   // R9
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !(tx_ready && tx_last)) |=> tx_valid);

endmodule

// File: rtl/pause_gen.sv
module pause_gen
   import pause_pkg::*;
#(
   parameter int LEVEL_W     = 10,
   parameter int TIME_W      = 16,
   parameter int PRESCALE_W  = 9,
   parameter int PAD_BYTES   = 42,
   parameter bit AT_OR_ABOVE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic [LEVEL_W-1:0] level_thresh,
   input  logic [TIME_W-1:0]  pause_len,
   input  logic [TIME_W-1:0]  refresh_lead,
   input  logic [47:0]        src_mac,
   input  logic               bit_tick,
   output logic               tx_valid,
   input  logic               tx_ready,
   output logic [7:0]         tx_data,
   output logic               tx_last
);
   logic              start;
   pause_kind_e       start_kind;
   logic              busy;
   logic              done_xoff;
   logic              done_xon;
   logic [TIME_W-1:0] remaining;

   pause_ctrl #(
      .LEVEL_W     (LEVEL_W),
      .TIME_W      (TIME_W),
      .AT_OR_ABOVE (AT_OR_ABOVE)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .fifo_level   (fifo_level),
      .level_thresh (level_thresh),
      .remaining    (remaining),
      .refresh_lead (refresh_lead),
      .ser_busy     (busy),
      .start        (start),
      .start_kind   (start_kind)
   );

   pause_timer #(
      .TIME_W     (TIME_W),
      .PRESCALE_W (PRESCALE_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .reload    (done_xoff),
      .clear     (done_xon),
      .load_val  (pause_len),
      .remaining (remaining)
   );

   pause_ser #(
      .TIME_W    (TIME_W),
      .PAD_BYTES (PAD_BYTES)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_kind (start_kind),
      .len_in     (pause_len),
      .sa_in      (src_mac),
      .busy       (busy),
      .done_xoff  (done_xoff),
      .done_xon   (done_xon),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .tx_data    (tx_data),
      .tx_last    (tx_last)
   );

   // R6
   xon_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_xon |=> (remaining == '0));

endmodule

// File: tb/sim_pause_gen.sv
module sim_pause_gen;
   localparam int CLK_PERIOD = 10;
   localparam int FRAME_LEN  = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  fifo_level = '0;
   logic [9:0]  level_thresh = 10'd100;
   logic [15:0] pause_len = 16'd5;
   logic [15:0] refresh_lead = 16'd2;
   logic [47:0] src_mac = 48'h0;
   logic        bit_tick = 1'b1;
   logic        tx_ready = 1'b0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;
   logic [9:0] lvl_hi = 10'd200;
   logic [9:0] lvl_lo = 10'd50;

   pause_gen u0 (
      .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .level_thresh(level_thresh),
      .pause_len(pause_len), .refresh_lead(refresh_lead), .src_mac(src_mac),
      .bit_tick(bit_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_last(tx_last)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !ended) begin
         fails  = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [7:0] exp_byte(input int i, input logic [47:0] sa, input logic [15:0] len);
      logic [7:0] da [6];
      da = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
      if (i < 6)       return da[i];
      if (i < 12)      return sa[47 - 8*(i-6) -: 8];
      if (i == 12)     return 8'h88;
      if (i == 13)     return 8'h08;
      if (i == 14)     return 8'h00;
      if (i == 15)     return 8'h01;
      if (i == 16)     return len[15:8];
      if (i == 17)     return len[7:0];
      return 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge after the last byte was accepted.
   task automatic recv_frame(input string tag, input logic [15:0] exp_len, input int glitch_at);
      int n = 0;
      int bad = 0;
      int first_bad = -1;
      int act_b = 0;
      int exp_b = 0;
      int lastbad = 0;
      int dropped = 0;
      int waited = 0;
      while (!tx_valid && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      chk(tx_valid, {tag, " frame start"}, tx_valid, 1);
      if (!tx_valid) return;
      waited = 0;
      while (n < FRAME_LEN && waited < 5000) begin
         tx_ready = ($urandom % 4) != 0;
         if (!tx_valid) dropped++;
         if (tx_valid && tx_ready) begin
            if (tx_data !== exp_byte(n, src_mac, exp_len) && first_bad < 0) begin
               first_bad = n;
               act_b = tx_data;
               exp_b = exp_byte(n, src_mac, exp_len);
            end
            if (tx_data !== exp_byte(n, src_mac, exp_len)) bad++;
            if (tx_last !== (n == FRAME_LEN-1)) lastbad++;
            n++;
            if (n == glitch_at)     fifo_level = lvl_lo;
            if (n == glitch_at + 3) fifo_level = lvl_hi;
         end
         @(negedge clk);
         waited++;
      end
      tx_ready = 1'b0;
      chk(bad == 0, {tag, " R3 frame bytes"}, act_b, exp_b);
      chk(lastbad == 0 && n == FRAME_LEN, {tag, " R3 last flag/length"}, n, FRAME_LEN);
      chk(dropped == 0, {tag, " R9 valid held"}, dropped, 0);
   endtask

   task automatic expect_quiet(input string tag, input int ncyc);
      int seen = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (tx_valid) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   initial begin
      int gap;
      void'($urandom(32'd1729));
      src_mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      repeat (4) @(negedge clk);
      chk(tx_valid == 1'b0 && tx_last == 1'b0, "R1 in reset", tx_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_valid == 1'b0 && tx_last == 1'b0, "R1 after reset", tx_valid, 0);

      // R7 / R2 boundary: level equal to threshold is not congestion
      fifo_level = level_thresh;
      expect_quiet("R2 equal level gives no frame", 200);
      fifo_level = lvl_lo;
      expect_quiet("R7 idle no frame", 100);

      // R2 first XOFF
      fifo_level = lvl_hi;
      recv_frame("R2 xoff", 16'd5, -10);

      // R5 refresh timing: (5-2)*512+1 cycles after completion
      gap = 1;
      while (!tx_valid && gap < 4000) begin
         @(negedge clk);
         gap++;
      end
      chk(gap >= 1535 && gap <= 1539, "R5 refresh gap", gap, 1537);
      recv_frame("R5 refresh", 16'd5, -10);

      // R6 XON when level drops with pause outstanding
      fifo_level = lvl_lo;
      gap = 0;
      while (!tx_valid && gap < 20) begin
         @(negedge clk);
         gap++;
      end
      chk(gap <= 2, "R6 xon promptly", gap, 1);
      recv_frame("R6 xon", 16'd0, -10);
      expect_quiet("R7 no frame after xon", 2000);

      // R8 held request: level clears then returns during an XOFF
      pause_len = 16'd100;
      fifo_level = lvl_hi;
      recv_frame("R8 xoff", 16'd100, 10);
      recv_frame("R8 pending xon", 16'd0, -10);
      recv_frame("R8 xoff after xon", 16'd100, -10);
      fifo_level = lvl_lo;
      recv_frame("R6 xon 2", 16'd0, -10);

      // randomised rounds
      for (int it = 0; it < 5; it++) begin
         level_thresh = 10'(10 + $urandom % 880);
         lvl_hi = level_thresh + 10'(1 + $urandom % 100);
         lvl_lo = (it == 0) ? level_thresh : 10'($urandom % (32'(level_thresh) + 1));
         src_mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         pause_len = 16'(20 + $urandom % 200);
         refresh_lead = 16'(1 + $urandom % 5);
         fifo_level = lvl_lo;
         expect_quiet("R7 random idle", 20);
         fifo_level = lvl_hi;
         recv_frame("R2 random xoff", pause_len, -10);
         repeat ($urandom % 50) @(negedge clk);
         fifo_level = lvl_lo;
         recv_frame("R6 random xon", 16'd0, -10);
      end

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule